// File: doc/BRIEF.md
# Floating-Point Rounding and Range-Control Unit

This unit turns an unrounded intermediate floating-point value into a rounded extended-precision result. The intermediate value has a sign and a 17-bit signed unbiased exponent. Its mantissa is a carry bit, an explicit integer bit and a 63-bit fraction. Below the fraction sit exact guard and round bits and a sticky bit. A precision control picks how many significant bits survive: 24, 53 or 64. A mode control picks nearest-even, toward zero, toward minus infinity or toward plus infinity.

The result is always written in extended encoding: a 15-bit exponent with a bias of 16383 and a 64-bit mantissa with an explicit integer bit. When a narrower precision is selected, the mantissa bits below that precision are zero. After rounding, the exponent is checked against the range of the selected precision. An out-of-range value is replaced by that precision's overflow or underflow value, still in extended encoding. Inexact, overflow and underflow flags come with every result.

The datapath is combinational and ends in one output register. With `valid_i` high, a new operand is accepted on every clock, and its result appears one cycle later.

Top module: `rnd_unit`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous clock, and the result fields show the operand accepted on that clock. While `rst_ni` is low, `valid_o`, `sign_o`, `exp_o`, `mant_o` and all flags are zero.
- R2: The `prec_i` encoding is 2'b00 extended (64 bits), 2'b01 single (24 bits), 2'b10 double (53 bits), and 2'b11 behaves as extended. A finite result keeps only the selected number of leading mantissa bits, and every lower bit of `mant_o` is zero.
- R3: With `mode_i`=2'b00 (nearest), the kept value is incremented when the first dropped bit is set and either a lower dropped bit or the kept LSB is set. An exact tie therefore goes to the even value.
- R4: With `mode_i`=2'b01 (toward zero) the kept value is never incremented. With 2'b10 (toward minus infinity) only negative inexact results are incremented. With 2'b11 (toward plus infinity) only positive inexact results are incremented.
- R5: A rounding carry out of the integer bit gives a mantissa of 0x8000000000000000 and raises the exponent by one, before the range check.
- R6: When the carry bit of the input is set, the mantissa is first shifted right by one and the exponent raised by one. The shifted-out fraction LSB becomes the guard bit, the old guard becomes the round bit, and the old round and sticky bits are ORed into sticky.
- R7: An in-range result has `exp_o` equal to the unbiased exponent plus 16383. The allowed unbiased range, checked after rounding, is -126..127 for single, -1022..1023 for double and -16382..16383 for extended.
- R8: On overflow, `overflow_o` and `inexact_o` are set. The result is infinity (`exp_o`=0x7FFF, `mant_o`=0) in nearest mode, in toward-minus-infinity mode for a negative value and in toward-plus-infinity mode for a positive value. Otherwise it is the largest finite value: exponent emax+16383 and a mantissa of as many leading ones as the precision keeps.
- R9: On underflow the output is a zero with the input sign (`exp_o`=0, `mant_o`=0), and `underflow_o` and `inexact_o` are set.
- R10: `inexact_o` is set exactly when some mantissa bit dropped at the selected precision is nonzero, or when an overflow or underflow occurred.
- R11: With both the carry and the integer bits clear, the output is a signed zero with no overflow or underflow flag. `inexact_o` is then the OR of the fraction, guard, round and sticky bits.
- R12: `overflow_o` and `underflow_o` are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand valid |
| sign_i | input | 1 | Operand sign |
| exp_i | input | 17 | Signed unbiased intermediate exponent |
| ovf_bit_i | input | 1 | Mantissa carry bit above the integer bit |
| int_bit_i | input | 1 | Explicit integer bit |
| frac_i | input | 63 | Fraction |
| guard_i | input | 1 | First bit below the fraction LSB |
| round_i | input | 1 | Second bit below the fraction LSB |
| sticky_i | input | 1 | OR of all lower bits |
| prec_i | input | 2 | Rounding precision select |
| mode_i | input | 2 | Rounding mode select |
| valid_o | output | 1 | Result valid |
| sign_o | output | 1 | Result sign |
| exp_o | output | 15 | Biased extended exponent |
| mant_o | output | 64 | Extended mantissa with explicit integer bit |
| inexact_o | output | 1 | Inexact flag |
| overflow_o | output | 1 | Overflow flag |
| underflow_o | output | 1 | Underflow flag |

## Verification
Some properties are checked on every cycle:
- the one-cycle valid pipeline;
- that the two range flags exclude each other;
- that overflow implies inexact;
- that a finite nonzero result is normalized;
- that single and double results have zeroed low mantissa bits;
- that toward-zero rounding never produces infinity.

Other behaviours need the directed scenarios, with hand-computed operands:
- the tie-to-even decision and the sign dependence of the directed modes;
- the carry renormalization and the pre-shift of a carry-bit input;
- the exact exponent limits of each precision, and the choice between infinity and the largest finite value.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  localparam int EXP_IN_W  = 17;
  localparam int FRAC_W    = 63;
  localparam int MANT_W    = FRAC_W + 1;
  localparam int X_W       = MANT_W + 3;
  localparam int EXP_W     = EXP_IN_W + 2;
  localparam int EXP_OUT_W = 15;
  localparam int EXT_BIAS  = (1 << (EXP_OUT_W - 1)) - 1;
  localparam int NUM_PREC  = 3;
  localparam int SEL_W     = $clog2(NUM_PREC);

  typedef enum logic [1:0] {
    PREC_EXT  = 2'b00,
    PREC_SGL  = 2'b01,
    PREC_DBL  = 2'b10,
    PREC_EXT2 = 2'b11
  } prec_e;

  typedef enum logic [1:0] {
    MODE_NEAR = 2'b00,
    MODE_ZERO = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_UP   = 2'b11
  } mode_e;

  // index 0 single, 1 double, 2 extended
  function automatic int keep_bits(input int idx);
    case (idx)
      0:       return 24;
      1:       return 53;
      default: return MANT_W;
    endcase
  endfunction

  function automatic int exp_max(input int idx);
    case (idx)
      0:       return 127;
      1:       return 1023;
      default: return EXT_BIAS;
    endcase
  endfunction

  function automatic int exp_min(input int idx);
    return 1 - exp_max(idx);
  endfunction
endpackage

// File: rtl/rnd_prenorm.sv
module rnd_prenorm
  import rnd_pkg::*;
(
  input  logic                    ovf_bit_i,
  input  logic                    int_bit_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic                    guard_i,
  input  logic                    round_i,
  input  logic                    sticky_i,
  input  logic signed [EXP_IN_W-1:0] exp_i,
  output logic [X_W-1:0]          x_o,
  output logic signed [EXP_W-1:0] exp_o
);
  logic signed [EXP_W-1:0] exp_ext;

  assign exp_ext = EXP_W'(exp_i);

  always_comb begin
    if (ovf_bit_i) begin
      // shift right one: fraction LSB drops into guard
      x_o   = {1'b1, int_bit_i, frac_i, guard_i, round_i | sticky_i};
      exp_o = exp_ext + EXP_W'(1);
    end else begin
      x_o   = {int_bit_i, frac_i, guard_i, round_i, sticky_i};
      exp_o = exp_ext;
    end
  end
endmodule

// File: rtl/rnd_round.sv
module rnd_round
  import rnd_pkg::*;
#(
  parameter int KEEP = 64
) (
  input  logic [X_W-1:0]    x_i,
  input  logic              sign_i,
  input  mode_e             mode_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              carry_o,
  output logic              inexact_o
);
  localparam int LSB = X_W - KEEP;

  logic [KEEP-1:0] kept;
  logic [KEEP-1:0] kept_rnd;
  logic [KEEP:0]   sum;
  logic            lsb, gb, rb, sb, inc;

  assign kept = x_i[X_W-1 -: KEEP];
  assign lsb  = x_i[LSB];
  assign gb   = x_i[LSB-1];
  assign rb   = x_i[LSB-2];
  assign sb   = |x_i[LSB-3:0];
  assign inexact_o = gb | rb | sb;

  always_comb begin
    case (mode_i)
      MODE_NEAR: inc = gb & (rb | sb | lsb);
      MODE_ZERO: inc = 1'b0;
      MODE_DOWN: inc = sign_i & inexact_o;
      default:   inc = ~sign_i & inexact_o;
    endcase
  end

  assign sum     = {1'b0, kept} + (KEEP+1)'(inc);
  assign carry_o = sum[KEEP];

  always_comb begin
    if (carry_o) kept_rnd = {1'b1, {(KEEP-1){1'b0}}};
    else         kept_rnd = sum[KEEP-1:0];
  end

  assign mant_o = MANT_W'(kept_rnd) << (MANT_W - KEEP);
endmodule

// File: rtl/rnd_range.sv
module rnd_range
  import rnd_pkg::*;
(
  input  logic                    sign_i,
  input  mode_e                   mode_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic                    is_zero_i,
  input  logic                    zero_inexact_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [MANT_W-1:0]       mant_i,
  input  logic                    inexact_i,
  output logic [EXP_OUT_W-1:0]    exp_o,
  output logic [MANT_W-1:0]       mant_o,
  output logic                    inexact_o,
  output logic                    overflow_o,
  output logic                    underflow_o
);
  logic signed [EXP_W-1:0] emax, emin;
  logic [MANT_W-1:0]       max_mant;
  logic                    to_inf, too_big, too_small;

  always_comb begin
    emax     = EXP_W'(exp_max(2));
    emin     = EXP_W'(exp_min(2));
    max_mant = {MANT_W{1'b1}};
    for (int i = 0; i < NUM_PREC; i++) begin
      if (int'(sel_i) == i) begin
        emax     = EXP_W'(exp_max(i));
        emin     = EXP_W'(exp_min(i));
        max_mant = {MANT_W{1'b1}} << (MANT_W - keep_bits(i));
      end
    end
  end

  assign too_big   = exp_i > emax;
  assign too_small = exp_i < emin;

  always_comb begin
    case (mode_i)
      MODE_NEAR: to_inf = 1'b1;
      MODE_ZERO: to_inf = 1'b0;
      MODE_DOWN: to_inf = sign_i;
      default:   to_inf = ~sign_i;
    endcase
  end

  always_comb begin
    exp_o       = '0;
    mant_o      = '0;
    inexact_o   = 1'b0;
    overflow_o  = 1'b0;
    underflow_o = 1'b0;
    if (is_zero_i) begin
      inexact_o = zero_inexact_i;
    end else if (too_big) begin
      overflow_o = 1'b1;
      inexact_o  = 1'b1;
      if (to_inf) begin
        exp_o = '1;
      end else begin
        exp_o  = EXP_OUT_W'(emax + EXP_W'(EXT_BIAS));
        mant_o = max_mant;
      end
    end else if (too_small) begin
      underflow_o = 1'b1;
      inexact_o   = 1'b1;
    end else begin
      exp_o     = EXP_OUT_W'(exp_i + EXP_W'(EXT_BIAS));
      mant_o    = mant_i;
      inexact_o = inexact_i;
    end
  end
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sign_i,
  input  logic [EXP_IN_W-1:0]  exp_i,
  input  logic                 ovf_bit_i,
  input  logic                 int_bit_i,
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic                 guard_i,
  input  logic                 round_i,
  input  logic                 sticky_i,
  input  logic [1:0]           prec_i,
  input  logic [1:0]           mode_i,
  output logic                 valid_o,
  output logic                 sign_o,
  output logic [EXP_OUT_W-1:0] exp_o,
  output logic [MANT_W-1:0]    mant_o,
  output logic                 inexact_o,
  output logic                 overflow_o,
  output logic                 underflow_o
);
  mode_e                   mode;
  logic [X_W-1:0]          x;
  logic signed [EXP_W-1:0] pre_exp, rnd_exp;
  logic [SEL_W-1:0]        sel;
  logic [MANT_W-1:0]       mant_p [NUM_PREC];
  logic                    carry_p [NUM_PREC];
  logic                    inx_p [NUM_PREC];
  logic [MANT_W-1:0]       mant_s;
  logic                    carry_s, inx_s;
  logic [EXP_OUT_W-1:0]    exp_d;
  logic [MANT_W-1:0]       mant_d;
  logic                    inx_d, ovf_d, unf_d;

  assign mode = mode_e'(mode_i);

  always_comb begin
    case (prec_i)
      PREC_SGL: sel = SEL_W'(0);
      PREC_DBL: sel = SEL_W'(1);
      default:  sel = SEL_W'(2);
    endcase
  end

  rnd_prenorm u_prenorm (
    .ovf_bit_i (ovf_bit_i),
    .int_bit_i (int_bit_i),
    .frac_i    (frac_i),
    .guard_i   (guard_i),
    .round_i   (round_i),
    .sticky_i  (sticky_i),
    .exp_i     (exp_i),
    .x_o       (x),
    .exp_o     (pre_exp)
  );

  for (genvar g = 0; g < NUM_PREC; g++) begin : g_prec
    rnd_round #(.KEEP(keep_bits(g))) u_round (
      .x_i       (x),
      .sign_i    (sign_i),
      .mode_i    (mode),
      .mant_o    (mant_p[g]),
      .carry_o   (carry_p[g]),
      .inexact_o (inx_p[g])
    );
  end

  always_comb begin
    mant_s  = mant_p[NUM_PREC-1];
    carry_s = carry_p[NUM_PREC-1];
    inx_s   = inx_p[NUM_PREC-1];
    for (int i = 0; i < NUM_PREC; i++) begin
      if (int'(sel) == i) begin
        mant_s  = mant_p[i];
        carry_s = carry_p[i];
        inx_s   = inx_p[i];
      end
    end
  end

  assign rnd_exp = pre_exp + EXP_W'(carry_s);

  rnd_range u_range (
    .sign_i         (sign_i),
    .mode_i         (mode),
    .sel_i          (sel),
    .is_zero_i      (~x[X_W-1]),
    .zero_inexact_i (|x[X_W-2:0]),
    .exp_i          (rnd_exp),
    .mant_i         (mant_s),
    .inexact_i      (inx_s),
    .exp_o          (exp_d),
    .mant_o         (mant_d),
    .inexact_o      (inx_d),
    .overflow_o     (ovf_d),
    .underflow_o    (unf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      sign_o      <= 1'b0;
      exp_o       <= '0;
      mant_o      <= '0;
      inexact_o   <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sign_o      <= sign_i;
        exp_o       <= exp_d;
        mant_o      <= mant_d;
        inexact_o   <= inx_d;
        overflow_o  <= ovf_d;
        underflow_o <= unf_d;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R2
  single_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i == PREC_SGL) |=> mant_o[MANT_W-keep_bits(0)-1:0] == '0);
  // R2
  double_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prec_i == PREC_DBL) |=> mant_o[MANT_W-keep_bits(1)-1:0] == '0);
  // R4
  zero_mode_no_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_ZERO) |=> exp_o != '1);
  // R8
  ovf_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && overflow_o) |-> inexact_o);
  // R9
  unf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && underflow_o) |-> (exp_o == '0 && mant_o == '0 && inexact_o));
  // R12
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(overflow_o && underflow_o));
  // R7
  finite_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exp_o != '0 && exp_o != '1) |-> mant_o[MANT_W-1]);
endmodule

// File: tb/tb_rnd_unit.sv
module tb_rnd_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [16:0] exp_i = '0;
  logic        ovf_bit_i = 1'b0;
  logic        int_bit_i = 1'b0;
  logic [62:0] frac_i = '0;
  logic        guard_i = 1'b0, round_i = 1'b0, sticky_i = 1'b0;
  logic [1:0]  prec_i = 2'b00, mode_i = 2'b00;
  logic        valid_o, sign_o, inexact_o, overflow_o, underflow_o;
  logic [14:0] exp_o;
  logic [63:0] mant_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] EXT = 2'b00, SGL = 2'b01, DBL = 2'b10, EX2 = 2'b11;
  localparam logic [1:0] RN = 2'b00, RZ = 2'b01, RM = 2'b10, RP = 2'b11;
  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  always #4 clk = ~clk;

  rnd_unit dut (.*, .clk_i(clk));

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic s, input int e, input logic ov, input logic ib,
                       input logic [62:0] f, input logic g, input logic r, input logic st,
                       input logic [1:0] p, input logic [1:0] m);
    @(negedge clk);
    sign_i = s; exp_i = 17'(e); ovf_bit_i = ov; int_bit_i = ib; frac_i = f;
    guard_i = g; round_i = r; sticky_i = st; prec_i = p; mode_i = m;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // packs {valid, sign, exp, mant, inexact, overflow, underflow}
  function automatic logic [127:0] res(input logic s, input logic [14:0] e,
                                       input logic [63:0] mt, input logic ix,
                                       input logic ov, input logic un);
    return 128'({1'b1, s, e, mt, ix, ov, un});
  endfunction

  function automatic logic [127:0] got();
    return 128'({valid_o, sign_o, exp_o, mant_o, inexact_o, overflow_o, underflow_o});
  endfunction

  task automatic t_reset();
    chk("R1 reset", got(), 128'd0);
  endtask

  task automatic t_exact_ext();
    apply(0, 0, 0, 1, '0, 0, 0, 0, EXT, RN);
    chk("R1 R7 exact", got(), res(0, 15'h3fff, ONE, 0, 0, 0));
    @(negedge clk);
    chk("R1 idle valid", 128'(valid_o), 128'd0);
  endtask

  task automatic t_nearest();
    apply(0, 0, 0, 1, '0, 1, 0, 0, EXT, RN);
    chk("R3 tie even stays", got(), res(0, 15'h3fff, ONE, 1, 0, 0));
    apply(0, 0, 0, 1, 63'd1, 1, 0, 0, EXT, RN);
    chk("R3 tie odd up", got(), res(0, 15'h3fff, ONE | 64'd2, 1, 0, 0));
    apply(0, 0, 0, 1, '0, 1, 0, 1, EXT, RN);
    chk("R3 above half", got(), res(0, 15'h3fff, ONE | 64'd1, 1, 0, 0));
    apply(0, 0, 0, 1, 63'd1, 1, 0, 0, EX2, RN);
    chk("R2 code 11 as ext", got(), res(0, 15'h3fff, ONE | 64'd2, 1, 0, 0));
  endtask

  task automatic t_directed();
    apply(0, 0, 0, 1, '0, 0, 1, 0, EXT, RZ);
    chk("R4 toward zero", got(), res(0, 15'h3fff, ONE, 1, 0, 0));
    apply(0, 0, 0, 1, '0, 0, 1, 0, EXT, RP);
    chk("R4 up positive", got(), res(0, 15'h3fff, ONE | 64'd1, 1, 0, 0));
    apply(0, 0, 0, 1, '0, 0, 1, 0, EXT, RM);
    chk("R4 down positive", got(), res(0, 15'h3fff, ONE, 1, 0, 0));
    apply(1, 0, 0, 1, '0, 0, 1, 0, EXT, RM);
    chk("R4 down negative", got(), res(1, 15'h3fff, ONE | 64'd1, 1, 0, 0));
    apply(1, 0, 0, 1, '0, 0, 0, 1, EXT, RP);
    chk("R4 up negative", got(), res(1, 15'h3fff, ONE, 1, 0, 0));
  endtask

  task automatic t_carry();
    apply(0, 0, 0, 1, '1, 1, 1, 0, EXT, RN);
    chk("R5 carry renorm", got(), res(0, 15'h4000, ONE, 1, 0, 0));
    apply(0, 5, 1, 1, '0, 0, 0, 0, EXT, RN);
    chk("R6 carry bit exact", got(), res(0, 15'h4005, 64'hC000_0000_0000_0000, 0, 0, 0));
    apply(0, 5, 1, 1, 63'd1, 0, 0, 0, EXT, RN);
    chk("R6 shifted lsb tie", got(), res(0, 15'h4005, 64'hC000_0000_0000_0000, 1, 0, 0));
    apply(0, 5, 1, 1, 63'd3, 0, 0, 0, EXT, RN);
    chk("R6 shifted odd up", got(), res(0, 15'h4005, 64'hC000_0000_0000_0002, 1, 0, 0));
  endtask

  task automatic t_precisions();
    apply(0, 0, 0, 1, 63'(1) << 39, 0, 0, 0, SGL, RN);
    chk("R2 R10 single tie", got(), res(0, 15'h3fff, ONE, 1, 0, 0));
    apply(0, 0, 0, 1, (63'(1) << 39) | 63'd1, 0, 0, 0, SGL, RN);
    chk("R2 R3 single up", got(), res(0, 15'h3fff, 64'h8000_0100_0000_0000, 1, 0, 0));
    apply(0, 0, 0, 1, 63'hC00, 0, 0, 0, DBL, RN);
    chk("R2 R3 double odd", got(), res(0, 15'h3fff, 64'h8000_0000_0000_1000, 1, 0, 0));
    apply(0, 0, 0, 1, 63'h800, 0, 0, 0, DBL, RZ);
    chk("R10 double exact", got(), res(0, 15'h3fff, 64'h8000_0000_0000_0800, 0, 0, 0));
  endtask

  task automatic t_overflow();
    apply(0, 127, 0, 1, '1, 1, 0, 0, SGL, RN);
    chk("R5 R8 single carry inf", got(), res(0, 15'h7fff, 64'd0, 1, 1, 0));
    apply(0, 128, 0, 1, '0, 0, 0, 0, SGL, RZ);
    chk("R8 single max zero-mode", got(), res(0, 15'h407e, 64'hFFFF_FF00_0000_0000, 1, 1, 0));
    apply(0, 128, 0, 1, '0, 0, 0, 0, SGL, RM);
    chk("R8 single max down-pos", got(), res(0, 15'h407e, 64'hFFFF_FF00_0000_0000, 1, 1, 0));
    apply(1, 128, 0, 1, '0, 0, 0, 0, SGL, RM);
    chk("R8 single inf down-neg", got(), res(1, 15'h7fff, 64'd0, 1, 1, 0));
    apply(0, 128, 0, 1, '0, 0, 0, 0, SGL, RP);
    chk("R8 single inf up-pos", got(), res(0, 15'h7fff, 64'd0, 1, 1, 0));
    apply(0, 127, 0, 1, '0, 0, 0, 0, SGL, RN);
    chk("R7 single emax ok", got(), res(0, 15'h407e, ONE, 0, 0, 0));
    apply(0, 1023, 0, 1, '0, 0, 0, 0, DBL, RN);
    chk("R7 double emax ok", got(), res(0, 15'h43fe, ONE, 0, 0, 0));
    apply(1, 1024, 0, 1, '0, 0, 0, 0, DBL, RZ);
    chk("R8 double max", got(), res(1, 15'h43fe, 64'hFFFF_FFFF_FFFF_F800, 1, 1, 0));
    apply(0, 16384, 0, 1, '0, 0, 0, 0, EXT, RN);
    chk("R8 ext inf", got(), res(0, 15'h7fff, 64'd0, 1, 1, 0));
    apply(0, 16384, 0, 1, '0, 0, 0, 0, EXT, RZ);
    chk("R8 ext max", got(), res(0, 15'h7ffe, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0));
    apply(0, 1024, 0, 1, '0, 0, 0, 0, EXT, RN);
    chk("R7 ext wide range", got(), res(0, 15'h43ff, ONE, 0, 0, 0));
  endtask

  task automatic t_underflow();
    apply(1, -127, 0, 1, '0, 0, 0, 0, SGL, RN);
    chk("R9 single underflow", got(), res(1, 15'h0, 64'd0, 1, 0, 1));
    apply(0, -126, 0, 1, '0, 0, 0, 0, SGL, RN);
    chk("R7 single emin ok", got(), res(0, 15'h3f81, ONE, 0, 0, 0));
    apply(0, -16383, 0, 1, '0, 0, 0, 0, EXT, RN);
    chk("R9 ext underflow", got(), res(0, 15'h0, 64'd0, 1, 0, 1));
    apply(0, -16382, 0, 1, '0, 0, 0, 0, EXT, RN);
    chk("R7 ext emin ok", got(), res(0, 15'h1, ONE, 0, 0, 0));
    apply(0, -127, 0, 1, '1, 1, 0, 0, SGL, RN);
    chk("R5 R7 carry lifts out", got(), res(0, 15'h3f81, ONE, 1, 0, 0));
  endtask

  task automatic t_zero();
    apply(1, 40, 0, 0, '0, 0, 0, 0, EXT, RN);
    chk("R11 exact zero", got(), res(1, 15'h0, 64'd0, 0, 0, 0));
    apply(0, 40, 0, 0, '0, 0, 0, 1, SGL, RN);
    chk("R11 zero sticky", got(), res(0, 15'h0, 64'd0, 1, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_exact_ext();
    t_nearest();
    t_directed();
    t_carry();
    t_precisions();
    t_overflow();
    t_underflow();
    t_zero();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule